// File: doc/BRIEF.md
# Register Readback OR-Bus

This block assembles the read data word of a register file. The decode logic supplies one select line per readable register. The block does not index the registers with the read address. Instead it gates each register's current value with that register's select line and combines all gated words with a bitwise OR. A hit bit runs alongside each gated word and is combined the same way. When a read selects no register, the result is zero data with an error flag.

The OR tree can be split into one, two or three register stages. With two stages, the first stage ORs groups of floor(sqrt(N)) words, and the second stage takes the remaining and larger fan-in. With three stages, the first two stages each use floor(cbrt(N)) groups, and the last stage takes what remains. Register values are gated and captured in the cycle of the request. A clear-on-read side effect in that same cycle therefore cannot change the returned value. The response strobe, the data and the error flag leave the block together, `STAGES` cycles after the request. Alias registers are served by their own select lines, even when two select lines present the same stored value.

Top module: `rb_orbus`

## Requirements
- R1: `rsp_vld` is high in exactly the cycle that follows by `STAGES` clock edges a cycle in which `rd_req` was high, and `rsp_vld` is low otherwise.
- R2: For a request with exactly one bit `k` of `rd_strb` set, `rsp_data` equals word `k` of `rd_words` (bits `k*DW` up to `k*DW+DW-1`) and `rsp_err` is 0.
- R3: For a request with `rd_strb` all zero, `rsp_data` is 0 and `rsp_err` is 1 in the response cycle.
- R4: The returned data is the value of `rd_words` in the request cycle. Any change to `rd_words` in later cycles, such as a clear caused by the read, does not alter it.
- R5: For a request with more than one strobe bit set, `rsp_data` is the bitwise OR of all selected words and `rsp_err` is 0.
- R6: When `rsp_vld` is low, `rsp_data` is 0 and `rsp_err` is 0. Strobe bits presented while `rd_req` is low produce no response.
- R7: After reset and before any request, `rsp_vld`, `rsp_data` and `rsp_err` are 0.
- R8: Requests in consecutive cycles each produce a response in consecutive cycles, in order and with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request in this cycle |
| rd_strb | input | N_REGS | One select line per readable register |
| rd_words | input | N_REGS*DW | Current readback values, register k at bits k*DW upward |
| rsp_vld | output | 1 | Response strobe returned to the host side |
| rsp_data | output | DW | OR-combined read data |
| rsp_err | output | 1 | Read selected no register |

## Verification
A read can reach the response side in the same cycle that the readback words change. The bench provokes this by drawing fresh random register values on every cycle, including the cycle straight after each request. In a directed case it also zeroes the selected word right after the request, as a clear-on-read would. Each response is judged against an expected value computed from the words captured at request time. A second overlap, two strobes in one cycle, is judged against the OR of both words with no error.

// File: rtl/rb_orbus_pkg.sv
package rb_orbus_pkg;

    // Integer k-th root, rounded down (elaboration-time helper).
    function automatic int unsigned iroot(input int unsigned n, input int unsigned k);
        int unsigned r;
        r = 1;
        for (int unsigned c = 1; c <= n; c++) begin
            int unsigned p;
            p = 1;
            for (int unsigned e = 0; e < k; e++) p = p * c;
            if (p <= n) r = c;
        end
        return r;
    endfunction

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/rb_mask_array.sv
module rb_mask_array #(
    parameter int unsigned N_REGS = 16,
    parameter int unsigned DW     = 32,
    localparam int unsigned EW    = DW + 1
) (
    input  logic                 rd_req,
    input  logic [N_REGS-1:0]    rd_strb,
    input  logic [N_REGS*DW-1:0] rd_words,
    output logic [N_REGS*EW-1:0] ent
);
    // Each entry: {hit, gated word}. Gated by request so idle cycles read zero.
    for (genvar k = 0; k < N_REGS; k++) begin : g_ent
        logic sel;
        assign sel = rd_req & rd_strb[k];
        assign ent[k*EW +: EW] = {sel, rd_words[k*DW +: DW] & {DW{sel}}};
    end
endmodule

// File: rtl/rb_or_stage.sv
module rb_or_stage
    import rb_orbus_pkg::*;
#(
    parameter int unsigned IN_CNT  = 16,
    parameter int unsigned GRP     = 4,
    parameter int unsigned EW      = 33,
    localparam int unsigned OUT_CNT = ceil_div(IN_CNT, GRP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [IN_CNT*EW-1:0]  in_ent,
    output logic                  out_vld,
    output logic [OUT_CNT*EW-1:0] out_ent
);
    for (genvar g = 0; g < OUT_CNT; g++) begin : g_grp
        logic [EW-1:0] mem [GRP];
        logic [EW-1:0] acc;

        for (genvar m = 0; m < GRP; m++) begin : g_mem
            if (g*GRP + m < IN_CNT) begin : g_used
                assign mem[m] = in_ent[(g*GRP+m)*EW +: EW];
            end else begin : g_pad
                assign mem[m] = '0;
            end
        end

        always_comb begin
            acc = '0;
            for (int m = 0; m < GRP; m++) acc = acc | mem[m];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_ent[g*EW +: EW] <= '0;
            else        out_ent[g*EW +: EW] <= acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end
endmodule

// File: rtl/rb_orbus.sv
module rb_orbus
    import rb_orbus_pkg::*;
#(
    parameter int unsigned N_REGS = 16,
    parameter int unsigned DW     = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [N_REGS-1:0]    rd_strb,
    input  logic [N_REGS*DW-1:0] rd_words,
    output logic                 rsp_vld,
    output logic [DW-1:0]        rsp_data,
    output logic                 rsp_err
);
    localparam int unsigned EW  = DW + 1;
    // two-stage split: smaller fan-in first
    localparam int unsigned G2  = iroot(N_REGS, 2);
    localparam int unsigned NG2 = ceil_div(N_REGS, G2);
    // three-stage split
    localparam int unsigned G3  = iroot(N_REGS, 3);
    localparam int unsigned NA3 = ceil_div(N_REGS, G3);
    localparam int unsigned NB3 = ceil_div(NA3, G3);

    logic [N_REGS*EW-1:0] ent;
    logic                 fin_vld;
    logic [EW-1:0]        fin_ent;

    rb_mask_array #(.N_REGS(N_REGS), .DW(DW)) u_mask (
        .rd_req  (rd_req),
        .rd_strb (rd_strb),
        .rd_words(rd_words),
        .ent     (ent)
    );

    if (STAGES == 1) begin : g_s1
        rb_or_stage #(.IN_CNT(N_REGS), .GRP(N_REGS), .EW(EW)) u_st0 (
            .clk(clk), .rst_n(rst_n), .in_vld(rd_req), .in_ent(ent),
            .out_vld(fin_vld), .out_ent(fin_ent));
    end else if (STAGES == 2) begin : g_s2
        logic                  v1;
        logic [NG2*EW-1:0]     e1;
        rb_or_stage #(.IN_CNT(N_REGS), .GRP(G2), .EW(EW)) u_st0 (
            .clk(clk), .rst_n(rst_n), .in_vld(rd_req), .in_ent(ent),
            .out_vld(v1), .out_ent(e1));
        rb_or_stage #(.IN_CNT(NG2), .GRP(NG2), .EW(EW)) u_st1 (
            .clk(clk), .rst_n(rst_n), .in_vld(v1), .in_ent(e1),
            .out_vld(fin_vld), .out_ent(fin_ent));
    end else begin : g_s3
        logic                  v1;
        logic                  v2;
        logic [NA3*EW-1:0]     e1;
        logic [NB3*EW-1:0]     e2;
        rb_or_stage #(.IN_CNT(N_REGS), .GRP(G3), .EW(EW)) u_st0 (
            .clk(clk), .rst_n(rst_n), .in_vld(rd_req), .in_ent(ent),
            .out_vld(v1), .out_ent(e1));
        rb_or_stage #(.IN_CNT(NA3), .GRP(G3), .EW(EW)) u_st1 (
            .clk(clk), .rst_n(rst_n), .in_vld(v1), .in_ent(e1),
            .out_vld(v2), .out_ent(e2));
        rb_or_stage #(.IN_CNT(NB3), .GRP(NB3), .EW(EW)) u_st2 (
            .clk(clk), .rst_n(rst_n), .in_vld(v2), .in_ent(e2),
            .out_vld(fin_vld), .out_ent(fin_ent));
    end

    assign rsp_vld  = fin_vld;
    assign rsp_data = fin_ent[DW-1:0];
    assign rsp_err  = fin_vld & ~fin_ent[DW];
endmodule

// File: rtl/rb_orbus_chk.sv
module rb_orbus_chk #(
    parameter int unsigned N_REGS = 16,
    parameter int unsigned DW     = 32,
    parameter int unsigned STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [N_REGS-1:0] rd_strb,
    input logic              rsp_vld,
    input logic [DW-1:0]     rsp_data,
    input logic              rsp_err
);
    logic [STAGES-1:0] req_sh;
    logic [STAGES-1:0] hit_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sh <= '0;
            hit_sh <= '0;
        end else begin
            req_sh[0] <= rd_req;
            hit_sh[0] <= rd_req & (|rd_strb);
            for (int i = 1; i < STAGES; i++) begin
                req_sh[i] <= req_sh[i-1];
                hit_sh[i] <= hit_sh[i-1];
            end
        end
    end

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld == req_sh[STAGES-1]); // R1
    AST_MISS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_err == !hit_sh[STAGES-1])); // R3
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_data == '0)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (rsp_data == '0 && !rsp_err)); // R6
endmodule

bind rb_orbus rb_orbus_chk #(.N_REGS(N_REGS), .DW(DW), .STAGES(STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_strb(rd_strb),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_err(rsp_err));

// File: tb/rb_orbus_tb.sv
module rb_orbus_tb;
    localparam int unsigned N      = 16;
    localparam int unsigned DW     = 32;
    localparam int unsigned STAGES = 2;
    localparam time         CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [N-1:0]      rd_strb = '0;
    logic [N*DW-1:0]   rd_words = '0;
    logic              rsp_vld;
    logic [DW-1:0]     rsp_data;
    logic              rsp_err;

    int checks = 0;
    int fails  = 0;

    // expected pipeline, index 0 = newest
    logic          ev [STAGES];
    logic [DW-1:0] ed [STAGES];
    logic          ee [STAGES];
    string         et [STAGES];

    always #(CLK_PERIOD/2) clk = ~clk;

    rb_orbus #(.N_REGS(N), .DW(DW), .STAGES(STAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_strb(rd_strb),
        .rd_words(rd_words), .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_err(rsp_err));

    function automatic logic [DW-1:0] exp_data(logic req, logic [N-1:0] s, logic [N*DW-1:0] w);
        logic [DW-1:0] d = '0;
        if (req) for (int k = 0; k < N; k++) if (s[k]) d |= w[k*DW +: DW];
        return d;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle at negedge: compare oldest expectation, then drive new inputs.
    task automatic step(logic req, logic [N-1:0] s, logic [N*DW-1:0] w, string tag);
        @(negedge clk);
        check("R1 vld", DW'(rsp_vld), DW'(ev[STAGES-1]));
        check({et[STAGES-1], " data"}, rsp_data, ed[STAGES-1]);
        check({et[STAGES-1], " err"}, DW'(rsp_err), DW'(ee[STAGES-1]));
        for (int i = STAGES-1; i > 0; i--) begin
            ev[i] = ev[i-1]; ed[i] = ed[i-1]; ee[i] = ee[i-1]; et[i] = et[i-1];
        end
        ev[0] = req;
        ed[0] = exp_data(req, s, w);
        ee[0] = req && (s == '0);
        et[0] = tag;
        rd_req = req; rd_strb = s; rd_words = w;
    endtask

    function automatic logic [N*DW-1:0] rand_words();
        logic [N*DW-1:0] w;
        for (int k = 0; k < N; k++) w[k*DW +: DW] = $urandom;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [N*DW-1:0] w;
        void'($urandom(32'h5eed_0b05));
        for (int i = 0; i < STAGES; i++) begin
            ev[i] = 1'b0; ed[i] = '0; ee[i] = 1'b0; et[i] = "R6";
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 vld", DW'(rsp_vld), '0);
        check("R7 data", rsp_data, '0);
        check("R7 err", DW'(rsp_err), '0);

        // R2 single strobe on each register, directed
        for (int k = 0; k < N; k++) step(1'b1, N'(1) << k, rand_words(), "R2");
        // R3 miss
        step(1'b1, '0, rand_words(), "R3");
        // R5 two strobes, alias-style: same value on both
        w = rand_words();
        w[5*DW +: DW] = w[9*DW +: DW];
        step(1'b1, N'(1) << 5 | N'(1) << 9, w, "R5");
        step(1'b1, N'(1) << 0 | N'(1) << (N-1), rand_words(), "R5");
        // R4 clear-on-read: selected word zeroed the cycle after request
        w = rand_words();
        w[3*DW +: DW] = 32'hA5A5_1234;
        step(1'b1, N'(1) << 3, w, "R4");
        w[3*DW +: DW] = '0;
        step(1'b0, '0, w, "R6");
        // R6 strobes with no request
        step(1'b0, N'(1) << 7, rand_words(), "R6");
        step(1'b0, '0, rand_words(), "R6");

        // R8 back-to-back random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned mode = $urandom % 8;
            logic [N-1:0] s;
            string tag;
            logic req = 1'b1;
            if (mode < 2) begin s = '0; tag = "R3"; end
            else if (mode < 6) begin s = N'(1) << ($urandom % N); tag = "R8"; end
            else if (mode == 6) begin s = N'($urandom) | (N'(1) << ($urandom % N)); tag = "R5"; end
            else begin s = N'($urandom); req = 1'b0; tag = "R6"; end
            step(req, s, rand_words(), tag);
        end
        for (int i = 0; i < STAGES + 1; i++) step(1'b0, '0, rand_words(), "R6");

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule